// File: doc/BRIEF.md
# One-Wire Byte Engine with One-Shot Strong Pullup

This block moves whole bytes over a one-wire bus. It contains its own slot timer, driven by a microsecond tick. A byte write becomes eight write slots. A logic 1 pulls the line low briefly and a logic 0 pulls it low for most of the slot. A byte read issues eight short-low read slots and samples the line part way through each one. The engine drives the line only through an open-drain "pull low" output and reads the line back on a separate input.

Software can arm a single strong-pullup request, given as a duration in milliseconds. The next byte write uses that request. The strong pullup switches on in the last slot of that write, as soon as the line is released. It stays on after the write for the requested number of milliseconds, and then the request clears itself. When the pullup enable is low, the engine still waits for the requested time but does not drive the pullup. A request of zero cancels an armed request. Byte reads leave the request untouched. A millisecond is counted as `MS_US` microsecond ticks.

Top module: `onewire_byte_xfer`

## Requirements
- R1: A write slot lasts `T_SLOT` ticks, 70 by default. Its low phase is `T_LOW1` ticks (6) for a 1 and `T_LOW0` ticks (60) for a 0. Bit i of `wdata` goes out in slot i, starting with bit 0.
- R2: A read issues eight slots, each with a `T_LOW1`-tick low phase. `line_in` is sampled `T_SAMP` ticks (15) into each slot. Sample i lands in `rdata` bit i, and `rdata` is updated when `done` pulses.
- R3: When a nonzero duration is armed and `pu_en` is high at the end of the seventh slot of a write, `strong_pu` goes high in the eighth slot as soon as the low phase ends. It is never high in any earlier slot or during a read.
- R4: After that write's last slot, the engine stays busy for exactly duration×`MS_US` ticks with `strong_pu` held high. It then drops `strong_pu`, pulses `done`, and clears the armed duration, so the next write gets no pullup.
- R5: Loading a duration of 0 cancels an armed request. The following write then behaves as if nothing had been armed.
- R6: If `pu_en` is low, an armed duration still adds duration×`MS_US` ticks after the write and is still cleared, but `strong_pu` stays low.
- R7: Byte reads neither add hold time nor clear the armed duration.
- R8: `busy` is high from the cycle after a command until `done` is shown. `done` is a one-cycle pulse. Commands and `pu_we` are ignored while busy. If both commands arrive together, the write wins.
- R9: After reset, `busy`, `done`, `drive_low` and `strong_pu` are low, `rdata` is 0, and no duration is armed.
- R10: `drive_low` and `strong_pu` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| wr_cmd | input | 1 | Start a byte write (sampled when idle) |
| rd_cmd | input | 1 | Start a byte read (sampled when idle) |
| wdata | input | 8 | Byte to write |
| rdata | output | 8 | Last byte read |
| busy | output | 1 | Transfer or pullup hold in progress |
| done | output | 1 | One-cycle completion pulse |
| pu_we | input | 1 | Load `pu_ms` as the armed pullup duration (when idle) |
| pu_ms | input | DUR_W | Pullup duration in milliseconds, 0 cancels |
| pu_en | input | 1 | Allow the strong pullup to be driven |
| line_in | input | 1 | Sensed bus level |
| drive_low | output | 1 | Open-drain pull-low request |
| strong_pu | output | 1 | Strong pullup drive |

## Verification
Random bytes are written against a bus model that decodes each slot from the length of its low phase. This separates a correct bit order and low-phase encoding from a reversed order or swapped timings. Random read patterns, returned by the model while the line is released, show whether samples land in the right bit position and at the right moment in the slot. Armed durations from 0 to 3 are crossed with both enable levels. Transfer length and the count of pullup cycles then distinguish a correct hold from one that is missing, too short, left armed after use, or driven while disabled. Directed sequences cover cancellation by zero, a read placed between arming and writing, and commands or arming issued while the engine is busy.

// File: rtl/onewire_byte_xfer.sv
module onewire_byte_xfer #(
  parameter int MS_US  = 1000,
  parameter int DUR_W  = 16,
  parameter int T_SLOT = 70,
  parameter int T_LOW0 = 60,
  parameter int T_LOW1 = 6,
  parameter int T_SAMP = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic             wr_cmd,
  input  logic             rd_cmd,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic             busy,
  output logic             done,
  input  logic             pu_we,
  input  logic [DUR_W-1:0] pu_ms,
  input  logic             pu_en,
  input  logic             line_in,
  output logic             drive_low,
  output logic             strong_pu
);
  localparam int UW = $clog2(T_SLOT + 1);
  localparam int MW = $clog2(MS_US + 1);

  typedef enum logic [1:0] {IDLE, SLOT, HOLD} st_t;

  st_t              state;
  logic [UW-1:0]    ucnt;
  logic [MW-1:0]    ms_div;
  logic [2:0]       bitcnt;
  logic [7:0]       shreg;
  logic             is_rd, sbit, pu_on;
  logic [DUR_W-1:0] pend_ms, hold_ms;

  wire          cur_bit  = is_rd | shreg[0];
  wire [UW-1:0] low_len  = cur_bit ? UW'(T_LOW1) : UW'(T_LOW0);
  wire          slot_end = (state == SLOT) && us_tick && (ucnt == UW'(T_SLOT - 1));
  wire          released = (state == HOLD) || (state == SLOT && ucnt >= low_len);

  assign busy      = (state != IDLE);
  assign drive_low = (state == SLOT) && (ucnt < low_len);
  assign strong_pu = pu_on && released;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= IDLE;
      ucnt    <= '0;
      ms_div  <= '0;
      bitcnt  <= '0;
      shreg   <= '0;
      is_rd   <= 1'b0;
      sbit    <= 1'b0;
      pu_on   <= 1'b0;
      pend_ms <= '0;
      hold_ms <= '0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        IDLE: begin
          if (pu_we) pend_ms <= pu_ms;
          if (wr_cmd || rd_cmd) begin
            state  <= SLOT;
            is_rd  <= !wr_cmd;
            shreg  <= wr_cmd ? wdata : 8'h00;
            bitcnt <= '0;
            ucnt   <= '0;
          end
        end
        SLOT: begin
          if (us_tick) begin
            ucnt <= ucnt + 1'b1;
            if (is_rd && ucnt == UW'(T_SAMP)) sbit <= line_in;
          end
          if (slot_end) begin
            ucnt   <= '0;
            shreg  <= {is_rd & sbit, shreg[7:1]};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == 3'd6 && !is_rd && pend_ms != '0 && pu_en) pu_on <= 1'b1;
            if (bitcnt == 3'd7) begin
              if (is_rd) begin
                rdata <= {sbit, shreg[7:1]};
                state <= IDLE;
                done  <= 1'b1;
              end else if (pend_ms != '0) begin
                state   <= HOLD;
                ms_div  <= '0;
                hold_ms <= pend_ms;
              end else begin
                state <= IDLE;
                done  <= 1'b1;
              end
            end
          end
        end
        HOLD: begin
          if (us_tick) begin
            if (ms_div == MW'(MS_US - 1)) begin
              ms_div <= '0;
              if (hold_ms == DUR_W'(1)) begin
                state   <= IDLE;
                done    <= 1'b1;
                pu_on   <= 1'b0;
                pend_ms <= '0;
              end else begin
                hold_ms <= hold_ms - 1'b1;
              end
            end else begin
              ms_div <= ms_div + 1'b1;
            end
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  // R10
  excl_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_low && strong_pu));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  low_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low |-> busy);
  // R7
  rd_keeps_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_rd) |=> (pend_ms == $past(pend_ms)));
  // R4
  req_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_rd) |-> (pend_ms == '0));
  // R3
  pu_last_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strong_pu |-> (!is_rd && (state == HOLD || bitcnt == 3'd7)));
endmodule

// File: tb/onewire_byte_xfer_test.sv
module onewire_byte_xfer_test;
  localparam int MS   = 20;
  localparam int SLOT = 70;
  localparam int BASE = 1 + 8 * SLOT;

  logic clk = 0, rst_n = 0, us_tick = 1;
  logic wr_cmd = 0, rd_cmd = 0, pu_we = 0, pu_en = 0;
  logic [7:0] wdata = 0;
  logic [15:0] pu_ms = 0;
  logic line_in = 1;
  logic [7:0] rdata;
  logic busy, done, drive_low, strong_pu;

  onewire_byte_xfer #(.MS_US(MS)) uut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .wr_cmd(wr_cmd), .rd_cmd(rd_cmd),
    .wdata(wdata), .rdata(rdata), .busy(busy), .done(done), .pu_we(pu_we),
    .pu_ms(pu_ms), .pu_en(pu_en), .line_in(line_in), .drive_low(drive_low),
    .strong_pu(strong_pu));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] resp = 0;
  logic [7:0] wcap = 0;
  int starts = 0, cur = 0, lowlen = 0, pu_cnt = 0, overlap = 0;
  logic prev_low = 0;

  always @(negedge clk) begin
    if (drive_low && strong_pu) overlap++;
    if (strong_pu) pu_cnt++;
    if (drive_low && !prev_low) begin cur = starts; starts++; lowlen = 0; end
    if (drive_low) lowlen++;
    if (!drive_low && prev_low) wcap[cur % 8] = (lowlen < 30);
    prev_low = drive_low;
    line_in = drive_low ? 1'b0 : resp[cur % 8];
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_cyc(input int n);
    return BASE + n * MS;
  endfunction

  function automatic int exp_pu(input logic [7:0] b, input int n, input logic en);
    if (n == 0 || !en) return 0;
    return (SLOT - (b[7] ? 6 : 60)) + n * MS;
  endfunction

  task automatic arm(input int n);
    @(negedge clk); pu_ms = 16'(n); pu_we = 1;
    @(negedge clk); pu_we = 0;
  endtask

  task automatic run(input logic wr, input logic [7:0] b, output int cyc, output int pu);
    int pu0;
    pu0 = pu_cnt;
    @(negedge clk); wdata = b; wr_cmd = wr; rd_cmd = !wr; cyc = 0;
    @(negedge clk); wr_cmd = 0; rd_cmd = 0; cyc = 1;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    if (!done) chk("R8 watchdog", 0, 1);
    @(negedge clk);
    pu = pu_cnt - pu0;
  endtask

  initial begin
    int cyc, pu, n;
    logic [7:0] b;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9 busy", busy, 0); chk("R9 done", done, 0);
    chk("R9 drive_low", drive_low, 0); chk("R9 strong_pu", strong_pu, 0);
    chk("R9 rdata", rdata, 0);
    run(1, 8'hA5, cyc, pu);
    chk("R9 no armed request cyc", cyc, BASE); chk("R1 byte A5", wcap, 8'hA5);

    // R1 R3 R4 R6 random writes
    for (int i = 0; i < 10; i++) begin
      b = 8'($urandom); n = int'($urandom % 4); pu_en = 1'($urandom);
      arm(n);
      run(1, b, cyc, pu);
      chk("R1 write bits", wcap, b);
      chk(pu_en ? "R4 hold length" : "R6 hold length", cyc, exp_cyc(n));
      chk(pu_en ? "R3 pullup cycles" : "R6 no pullup", pu, exp_pu(b, n, pu_en));
      run(1, ~b, cyc, pu);
      chk("R4 request cleared", cyc, BASE); chk("R4 no second pullup", pu, 0);
    end
    // R1 corner bytes
    pu_en = 1;
    arm(1); run(1, 8'h80, cyc, pu); chk("R3 pullup bit7=1", pu, exp_pu(8'h80, 1, 1));
    arm(2); run(1, 8'h7F, cyc, pu); chk("R3 pullup bit7=0", pu, exp_pu(8'h7F, 2, 1));
    chk("R1 byte 7F", wcap, 8'h7F);

    // R2 random reads
    for (int i = 0; i < 8; i++) begin
      resp = 8'($urandom);
      run(0, 8'h00, cyc, pu);
      chk("R2 read data", rdata, resp);
      chk("R2 read length", cyc, BASE);
    end
    resp = 8'h01; run(0, 8'h00, cyc, pu); chk("R2 only bit0", rdata, 8'h01);
    resp = 8'h80; run(0, 8'h00, cyc, pu); chk("R2 only bit7", rdata, 8'h80);

    // R5 cancel
    arm(3); arm(0);
    run(1, 8'h3C, cyc, pu); chk("R5 cancel cyc", cyc, BASE); chk("R5 cancel pu", pu, 0);

    // R7 read between arm and write
    arm(2); resp = 8'h5A;
    run(0, 8'h00, cyc, pu);
    chk("R7 read no hold", cyc, BASE); chk("R7 read no pullup", pu, 0);
    chk("R2 read 5A", rdata, 8'h5A);
    run(1, 8'hC3, cyc, pu);
    chk("R7 request survives", cyc, exp_cyc(2)); chk("R7 pullup after read", pu, exp_pu(8'hC3, 2, 1));

    // R8 commands and arming while busy
    @(negedge clk); wdata = 8'h11; wr_cmd = 1; rd_cmd = 1;
    @(negedge clk); wr_cmd = 0; rd_cmd = 0;
    chk("R8 busy after cmd", busy, 1);
    repeat (50) @(negedge clk);
    rd_cmd = 1; pu_ms = 3; pu_we = 1; wdata = 8'hFF;
    @(negedge clk); rd_cmd = 0; pu_we = 0;
    while (!done) @(negedge clk);
    chk("R8 write wins", wcap, 8'h11);
    @(negedge clk);
    chk("R8 done one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk("R8 busy command ignored", busy, 0);
    run(1, 8'h22, cyc, pu);
    chk("R8 busy arming ignored", cyc, BASE);

    chk("R10 no overlap", overlap, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    checks++; fails++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule